// File: doc/BRIEF.md
# Four-Slot Skip-Transition Branch Direction Predictor

This block predicts the direction of conditional branches for an instruction fetch stage. It keeps a small direct-mapped table of 2-bit states, selected by the word-index bits of the program counter. During fetch, the lookup port takes an address and returns a taken or not-taken guess in the same cycle, with no register on the way. When a branch resolves, the update port receives the branch address and the real outcome. The matching entry then moves to its next state at the following clock edge.

The state machine in each entry is not the usual saturating counter. It is asymmetric:
- A taken outcome seen in the weak not-taken state jumps straight to strong taken.
- A not-taken outcome seen in either taken state below strong taken drops all the way to strong not-taken.
- Strong taken falls back only to weak taken.

The block also counts mispredictions. An update counts as a misprediction when its outcome disagrees with the guess the entry held before that update.

Top module: `skip_bht`

## Requirements
- R1: After reset every entry holds state 00, so every lookup predicts not taken, and `miss_count` is zero.
- R2: The prediction is the high bit of the selected state. States 00 and 01 give `lk_taken`=0, and states 10 and 11 give `lk_taken`=1.
- R3: The entry is selected by address bits [3:2]. All other address bits, on both ports, have no effect on which entry is used.
- R4: With state 00, a taken update moves the entry to 01, and a not-taken update leaves it at 00.
- R5: With state 01, a taken update moves the entry to 11, and a not-taken update moves it to 00.
- R6: With state 10, a taken update moves the entry to 11, and a not-taken update moves it to 00.
- R7: With state 11, a taken update leaves it at 11, and a not-taken update moves it to 10.
- R8: The lookup is combinational. When an update and a lookup select the same entry in one cycle, the lookup returns the prediction from before the update. The new state is visible from the next cycle on.
- R9: `miss_count` increases by one at the clock edge of each accepted update whose outcome differs from the entry's pre-update prediction. Otherwise it is unchanged.
- R10: While `up_valid` is 0, no entry changes, whatever `up_pc` and `up_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | ADDR_W (32) | Fetch address to predict for |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | ADDR_W (32) | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| miss_count | output | MISS_W (16) | Number of mispredicted updates since reset |

## Verification
A corrupted entry shows up on `lk_taken` in the very next lookup of that slot only if the high bit is wrong. A wrong low bit stays hidden until a later update takes the slot down a different path, which can be two or three updates later. The stimulus therefore walks each slot through every arc of the transition table and probes the slot after each step. The misprediction count is compared on every cycle. This exposes a wrong pre-update prediction within one clock edge, even when the visible prediction has already recovered.

// File: rtl/skip_bht_pkg.sv
package skip_bht_pkg;

  typedef enum logic [1:0] {
    ST_NT_HARD = 2'b00,
    ST_NT_SOFT = 2'b01,
    ST_T_SOFT  = 2'b10,
    ST_T_HARD  = 2'b11
  } bht_state_t;

  // Direction guessed by a state: upper half of the encoding means taken.
  function automatic logic state_predicts(input bht_state_t s);
    return (s == ST_T_SOFT) || (s == ST_T_HARD);
  endfunction

  // Skip-style transition: weak not-taken leaps to strong taken,
  // weak taken collapses to strong not-taken.
  function automatic bht_state_t state_next(input bht_state_t s, input logic taken);
    bht_state_t n;
    unique case (s)
      ST_NT_HARD: n = taken ? ST_NT_SOFT : ST_NT_HARD;
      ST_NT_SOFT: n = taken ? ST_T_HARD  : ST_NT_HARD;
      ST_T_SOFT:  n = taken ? ST_T_HARD  : ST_NT_HARD;
      ST_T_HARD:  n = taken ? ST_T_HARD  : ST_T_SOFT;
      default:    n = ST_NT_HARD;
    endcase
    return n;
  endfunction

  // An outcome is a miss when it disagrees with the guess of the old state.
  function automatic logic is_miss(input bht_state_t s, input logic taken);
    return state_predicts(s) != taken;
  endfunction

endpackage

// File: rtl/skip_bht_index.sv
module skip_bht_index #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  parameter int IDX_W      = 2
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx
);
  localparam int LSB = ALIGN_BITS;
  localparam int MSB = ALIGN_BITS + IDX_W - 1;

  assign idx = pc[MSB:LSB];

  // Bits outside the index window are deliberately unused.
  logic unused_bits;
  assign unused_bits = ^{pc[ADDR_W-1:MSB+1], pc[LSB-1:0]};
endmodule

// File: rtl/skip_bht_slot.sv
module skip_bht_slot
  import skip_bht_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       taken,
  output bht_state_t state
);
  bht_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= ST_NT_HARD;
    else if (we) state_q <= state_next(state_q, taken);
  end

  assign state = state_q;
endmodule

// File: rtl/skip_bht_misscnt.sv
module skip_bht_misscnt #(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bump,
  output logic [MISS_W-1:0] count
);
  logic [MISS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (bump) cnt_q <= cnt_q + MISS_W'(1);
  end

  assign count = cnt_q;
endmodule

// File: rtl/skip_bht.sv
module skip_bht
  import skip_bht_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2,
  parameter int NUM_SLOTS  = 4,
  parameter int MISS_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  output logic [MISS_W-1:0] miss_count
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int VEC_W = NUM_SLOTS * 2;

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;
  bht_state_t       slot_st [NUM_SLOTS];
  logic [VEC_W-1:0] slot_vec;   // flattened state view for the checker
  bht_state_t       lk_state;
  bht_state_t       upd_old;
  logic             upd_fire;
  logic             upd_miss;

  skip_bht_index #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W))
    u_lk_index (.pc(lk_pc), .idx(lk_idx));

  skip_bht_index #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W))
    u_up_index (.pc(up_pc), .idx(upd_idx));

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic we;
      assign we = up_valid && (upd_idx == IDX_W'(g));
      skip_bht_slot u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .taken (up_taken),
        .state (slot_st[g])
      );
      assign slot_vec[g*2 +: 2] = slot_st[g];
    end
  endgenerate

  // Lookup and update both read the registered state, so a same-cycle
  // update to the looked-up slot is not seen until the next cycle.
  assign lk_state = slot_st[lk_idx];
  assign upd_old  = slot_st[upd_idx];
  assign lk_taken = state_predicts(lk_state);
  assign upd_fire = up_valid;
  assign upd_miss = upd_fire && is_miss(upd_old, up_taken);

  skip_bht_misscnt #(.MISS_W(MISS_W)) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (upd_miss),
    .count (miss_count)
  );
endmodule

// File: rtl/skip_bht_chk.sv
module skip_bht_chk #(
  parameter int IDX_W  = 2,
  parameter int VEC_W  = 8,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_fire,
  input logic              upd_miss,
  input logic              up_taken,
  input logic [IDX_W-1:0]  upd_idx,
  input logic [1:0]        upd_old,
  input logic [VEC_W-1:0]  slot_vec,
  input logic [MISS_W-1:0] miss_count
);
  // R9
  miss_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_miss |=> miss_count == $past(miss_count) + MISS_W'(1));

  // R9
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_miss |=> $stable(miss_count));

  // R5
  soft_nt_leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && upd_old == 2'b01 && up_taken)
    |=> slot_vec[int'($past(upd_idx))*2 +: 2] == 2'b11);

  // R6
  soft_t_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && upd_old == 2'b10 && !up_taken)
    |=> slot_vec[int'($past(upd_idx))*2 +: 2] == 2'b00);

  // R7
  hard_t_ease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && upd_old == 2'b11 && !up_taken)
    |=> slot_vec[int'($past(upd_idx))*2 +: 2] == 2'b10);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(slot_vec));
endmodule

bind skip_bht skip_bht_chk #(.IDX_W(IDX_W), .VEC_W(VEC_W), .MISS_W(MISS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_fire   (upd_fire),
  .upd_miss   (upd_miss),
  .up_taken   (up_taken),
  .upd_idx    (upd_idx),
  .upd_old    (upd_old),
  .slot_vec   (slot_vec),
  .miss_count (miss_count)
);

// File: tb/test_skip_bht.sv
module test_skip_bht;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [15:0] miss_count;

  always #2 clk = ~clk;   // 250 MHz

  skip_bht i_skip_bht (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .miss_count(miss_count)
  );

  typedef struct {
    logic        pred;
    logic [15:0] miss;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [1:0]  model [4];
  logic [15:0] miss_m;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 0;

  // Expected next state, written from the requirement table.
  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic t);
    if (t) return (s == 2'b00) ? 2'b01 : 2'b11;            // R4 R5 R6 R7 taken arcs
    if (s == 2'b11) return 2'b10;                          // R7 not-taken arc
    return 2'b00;                                          // R4 R5 R6 not-taken arcs
  endfunction

  task automatic step(input logic v, input logic [31:0] upc, input logic t,
                      input logic [31:0] lpc, input string tag);
    exp_t e;
    logic [1:0] ui;
    @(negedge clk);
    up_valid = v; up_pc = upc; up_taken = t; lk_pc = lpc;
    e.pred = model[lpc[3:2]][1];
    e.miss = miss_m;
    e.tag  = tag;
    sb.push_back(e);
    if (v) begin
      ui = upc[3:2];
      if (model[ui][1] != t) miss_m = miss_m + 16'd1;
      model[ui] = ref_next(model[ui], t);
    end
  endtask

  task automatic probe(input int slot, input string tag);
    step(1'b0, 32'h0, 1'b0, 32'(slot) << 2, tag);
  endtask

  task automatic upd(input int slot, input logic t, input string tag);
    step(1'b1, 32'(slot) << 2, t, 32'(slot) << 2, tag);
    probe(slot, tag);
  endtask

  // Monitor: compare just before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if (lk_taken !== e.pred) begin
          n_bad++;
          $display("FAIL %s lk_taken got %0b exp %0b", e.tag, lk_taken, e.pred);
        end
        if (miss_count !== e.miss) begin
          n_bad++;
          $display("FAIL %s R9 miss_count got %0d exp %0d", e.tag, miss_count, e.miss);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 4; i++) model[i] = 2'b00;
    miss_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all slots not taken, counter zero
    for (int i = 0; i < 4; i++) probe(i, "R1");
    // R4: 00 stays on not taken, goes to 01 on taken
    upd(0, 1'b0, "R4");
    upd(0, 1'b1, "R4");
    // R5: 01 taken leaps to 11
    upd(0, 1'b1, "R5");
    // R7: 11 not taken to 10, taken stays 11
    upd(0, 1'b0, "R7");
    upd(0, 1'b1, "R6");        // R6: 10 taken to 11
    upd(0, 1'b1, "R7");
    upd(0, 1'b0, "R7");
    upd(0, 1'b0, "R6");        // R6: 10 not taken to 00
    upd(0, 1'b1, "R4");        // 00 -> 01: still not taken
    // R5: 01 not taken back to 00, then taken only reaches 01
    upd(1, 1'b1, "R5");
    upd(1, 1'b0, "R5");
    upd(1, 1'b1, "R5");
    upd(1, 1'b1, "R5");
    // R8: same-cycle update and lookup on slot 2 sees the old state
    step(1'b1, 32'h8, 1'b1, 32'h8, "R8");
    step(1'b1, 32'h8, 1'b1, 32'h8, "R8");
    step(1'b1, 32'h8, 1'b0, 32'h8, "R8");
    probe(2, "R8");
    // R10: up_valid low with live data changes nothing
    for (int i = 0; i < 6; i++) step(1'b0, 32'(i % 4) << 2, 1'b1, 32'(i % 4) << 2, "R10");
    for (int i = 0; i < 4; i++) probe(i, "R10");
    // R3: high and low address bits are ignored on both ports
    step(1'b1, 32'hFFFF_FF0F, 1'b1, 32'h1234_5673, "R3");
    step(1'b1, 32'h8000_004F, 1'b1, 32'h0000_00FC, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 32'h0, 1'b0, 32'hABCD_0000 | (32'(i) << 2) | 32'h1, "R3");
    // R2 and R9 under a pseudo-random mix of updates and lookups
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], {lfsr, lfsr[15:0]}, lfsr[5], {lfsr[7:0], lfsr, lfsr[11:4]}, "R2 R9");
    end
    step(1'b0, 32'h0, 1'b0, 32'h0, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule